// File: doc/BRIEF.md
# Programmable Loopback Pulse-Rate Divider

This block divides a stream of single-cycle input pulses by any whole number from 1 up to 2^STAGES. Its core is a chain of STAGES toggle stages that count input pulses in binary. When the last stage carries out, the block emits one output pulse. That same pulse is fed back to the chain: every stage whose control bit is set is forced to its "one" state, and every other stage is cleared to zero. A stage held at one this way no longer takes part in the count, so the chain restarts at the value K instead of zero. The divide factor is therefore 2^STAGES − K. With K = 0 the block is a plain binary divider. With every bit set, each input pulse passes straight through.

The control word K is loaded one bit at a time through a single serial pin with its own shift strobe. Loading never resets the count: a new K is picked up at the next wrap of the chain. The output period is therefore correct for the new setting once 2^STAGES input pulses have passed.

Besides the output pulse strobe, a square-wave output flips on every output pulse, which halves the rate once more. Input and output pulses are plain strobes, not a handshaked stream. The block accepts an input pulse in every clock cycle and has no back-pressure. Cycles without an input pulse do not advance the count.

Top module: `pulse_rate_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_pulse` and `out_square` are 0. Reset clears the count and the control word to zero, so the first output pulse after reset comes on exactly the 2^STAGES-th input pulse.
- R2: With K = 0, the chain divides by 2^STAGES: consecutive output pulses are 2^STAGES input pulses apart.
- R3: For any K in 0..2^STAGES−1, once settled, consecutive output pulses are exactly 2^STAGES − K input pulses apart. For example, with STAGES=4, K=11 gives 5 and K=6 gives 10; with STAGES=10, K=524 gives 500.
- R4: With all K bits set (K = 2^STAGES − 1), every input pulse produces an output pulse (divide by 1).
- R5: Each cycle with `ctrl_shift` high moves `ctrl_bit` into K bit 0, and every older bit moves up one position. After STAGES strobes, the first bit shifted in is K's most significant bit. Bits shifted beyond STAGES are lost. K does not change in cycles without `ctrl_shift`.
- R6: `out_pulse` is high for exactly one cycle: the cycle right after the clock edge that samples the completing `in_pulse`. It is never high after an edge at which `in_pulse` was low. Idle cycles neither advance the count nor change any stage.
- R7: `out_square` inverts on every output pulse and holds its value otherwise.
- R8: A new K takes effect at the next wrap of the chain. Once 2^STAGES input pulses have passed after the load, the period is 2^STAGES − K_new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_pulse | input | 1 | Input pulse strobe, one per counted event |
| ctrl_bit | input | 1 | Serial control-word data |
| ctrl_shift | input | 1 | Shift strobe for the control word |
| out_pulse | output | 1 | Divided output pulse strobe |
| out_square | output | 1 | Square wave that flips on each output pulse |

## Verification
The result of an input pulse is due in the cycle after the edge that samples it. The bench raises `in_pulse` on a falling edge and samples both outputs at the following falling edge. It also confirms that `out_pulse` stays low through every random idle gap. After a new K is loaded, the bench discards 2^STAGES + 1 input pulses so that the old count has been flushed. It then finds an output pulse and counts input pulses over two full periods, comparing each count with 2^STAGES − K. Each time it also checks that `out_square` has flipped.

// File: rtl/prd_pkg.sv
package prd_pkg;
  // Number of input pulses between output pulses for a given control word.
  function automatic int unsigned ratio_of(int unsigned stages, int unsigned k);
    return (32'd1 << stages) - k;
  endfunction
endpackage

// File: rtl/prd_ctrl_shift.sv
module prd_ctrl_shift #(
  parameter int STAGES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [STAGES-1:0] word
);
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) word <= '0;
        else if (shift_en) word <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) word <= '0;
        else if (shift_en) word <= {word[STAGES-2:0], bit_in};
      end
    end
  endgenerate

  // R5: control word only moves on a shift strobe
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word));
endmodule

// File: rtl/prd_stage.sv
module prd_stage (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic carry_in,
  input  logic wrap,
  input  logic shunt,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (pulse) begin
      if (wrap) q <= shunt;
      else if (carry_in) q <= ~q;
    end
  end

  // R6: idle cycles leave the stage untouched
  assert_stage_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !pulse |=> $stable(q));
endmodule

// File: rtl/pulse_rate_divider.sv
module pulse_rate_divider #(
  parameter int STAGES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic in_pulse,
  input  logic ctrl_bit,
  input  logic ctrl_shift,
  output logic out_pulse,
  output logic out_square
);
  import prd_pkg::*;

  localparam int unsigned FULL_RATIO = ratio_of(STAGES, 0);

  logic [STAGES-1:0] k_word;
  logic [STAGES-1:0] q;
  logic [STAGES:0]   carry;
  logic              wrap;

  prd_ctrl_shift #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .shift_en(ctrl_shift), .bit_in(ctrl_bit), .word(k_word)
  );

  assign carry[0] = in_pulse;
  assign wrap     = carry[STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      assign carry[i+1] = carry[i] & q[i];
      prd_stage u_stage (
        .clk(clk), .rst(rst), .pulse(in_pulse), .carry_in(carry[i]),
        .wrap(wrap), .shunt(k_word[i]), .q(q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pulse  <= 1'b0;
      out_square <= 1'b0;
    end else begin
      out_pulse <= wrap;
      if (wrap) out_square <= ~out_square;
    end
  end

  // R6: an output pulse always follows an accepted input pulse
  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
    out_pulse |-> $past(in_pulse));
  // R7: square output flips with each output pulse
  assert_square_flip_R7: assert property (@(posedge clk) disable iff (rst)
    out_pulse |-> (out_square != $past(out_square)));
  assert_square_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_pulse |-> $stable(out_square));
  // R3: the full ratio must fit the counter width
  initial assert_ratio_fits_R3: assert (FULL_RATIO >= 2);
endmodule

// File: tb/sim_pulse_rate_divider.sv
module sim_pulse_rate_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 0, sb_a = 0, sh_a = 0, in_b = 0, sb_b = 0, sh_b = 0;
  logic out_a, sq_a, out_b, sq_b;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pulse_rate_divider #(.STAGES(4)) u0 (
    .clk(clk), .rst(rst), .in_pulse(in_a), .ctrl_bit(sb_a), .ctrl_shift(sh_a),
    .out_pulse(out_a), .out_square(sq_a));
  pulse_rate_divider #(.STAGES(10)) u1 (
    .clk(clk), .rst(rst), .in_pulse(in_b), .ctrl_bit(sb_b), .ctrl_shift(sh_b),
    .out_pulse(out_b), .out_square(sq_b));

  function automatic int exp_ratio(int n, int k);
    return (1 << n) - k;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one input pulse on instance b (1 = 10-stage), then a random idle gap
  task automatic step(input bit b, output bit o, output bit s);
    int gap;
    if (b) in_b = 1; else in_a = 1;
    @(negedge clk);
    in_a = 0; in_b = 0;
    o = b ? out_b : out_a;
    s = b ? sq_b : sq_a;
    gap = b ? $urandom_range(1, 0) : $urandom_range(2, 0);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if ((b ? out_b : out_a) !== 1'b0) check("R6 idle", 1, 0);
    end
  endtask

  task automatic shift_bit(input bit b, input bit v);
    if (b) begin sb_b = v; sh_b = 1; end else begin sb_a = v; sh_a = 1; end
    @(negedge clk);
    sh_a = 0; sh_b = 0;
  endtask

  task automatic measure(input bit b, input int exp, input string tag);
    int n = b ? 10 : 4;
    bit o, s, prev_s;
    int cnt;
    // R8: flush old count
    for (int i = 0; i < (1 << n) + 1; i++) step(b, o, s);
    cnt = 0;
    do begin step(b, o, s); cnt++; end while (!o && cnt <= (1 << n) + 1);
    check({tag, " sync"}, int'(o), 1);
    prev_s = s;
    for (int r = 0; r < 2; r++) begin
      cnt = 0;
      do begin step(b, o, s); cnt++; end while (!o && cnt <= (1 << n) + 1);
      check(tag, cnt, exp);
      check("R7 square flip", int'(s), int'(!prev_s));
      prev_s = s;
    end
  endtask

  task automatic run(input bit b, input int k);
    int n = b ? 10 : 4;
    string tag;
    for (int i = n - 1; i >= 0; i--) shift_bit(b, k[i]);
    if (k == 0) tag = "R2 K=0";
    else if (k == (1 << n) - 1) tag = "R4 all-ones";
    else tag = "R3 ratio";
    tag = $sformatf("%s n=%0d k=%0d", tag, n, k);
    measure(b, exp_ratio(n, k), tag);
  endtask

  initial begin
    bit o, s;
    int first;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check("R1 out_pulse in reset", int'(out_a | out_b), 0);
    check("R1 out_square in reset", int'(sq_a | sq_b), 0);
    rst = 0;
    @(negedge clk);
    check("R1 out after reset", int'(out_a | sq_a | out_b | sq_b), 0);
    // R1/R2: from reset, first output on the 16th pulse
    first = 0;
    for (int i = 1; i <= 16; i++) begin
      step(0, o, s);
      if (o && first == 0) first = i;
    end
    check("R1 first output pulse index", first, 16);
    // documented points
    run(0, 11);
    run(0, 6);
    // R5: extra leading bits drop out; 6 bits -> K=0110
    shift_bit(0, 1); shift_bit(0, 1);
    shift_bit(0, 0); shift_bit(0, 1); shift_bit(0, 1); shift_bit(0, 0);
    measure(0, 10, "R5 serial load K=6");
    // every K on the 4-stage instance
    for (int k = 0; k < 16; k++) run(0, k);
    // selected K on the 10-stage instance
    run(1, 0);
    run(1, 524);
    run(1, 1023);
    run(1, 1);
    run(1, 512);
    for (int r = 0; r < 2; r++) run(1, $urandom_range(1023, 0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule